// File: doc/BRIEF.md
# Compare-value system timer channel

This block is a single timer channel driven by a free-running 64-bit tick counter. Software programs an absolute 64-bit deadline, or a signed 32-bit "ticks from now" value that is turned into the same deadline. The channel compares the running count against that deadline. It exposes a status bit that reports the expiry while the channel is enabled, and it drives a level interrupt that can be masked without hiding the status.

All accesses use a flat register port. There is a write strobe, a 2-bit select, a 64-bit write word and a combinational 64-bit read word. The select picks one of four views: running count (0), absolute deadline (1), relative view (2) and control (3). An interrupt handler typically writes enable plus mask to silence the line. It can then reprogram the deadline, or clear the mask to pick the level up again.

Top module: `cmpt_channel`

## Requirements
- R1: The running count is zero in reset and rises by exactly one per clock afterwards. Select 0 reads it, and writes to select 0 have no effect on it.
- R2: Select 1 writes and reads back the full 64-bit absolute deadline.
- R3: The expiry condition is the unsigned comparison count >= deadline. A deadline already at or below the count makes it true at once.
- R4: Select 3 reads enable in bit 0, mask in bit 1 and status in bit 2, with every higher bit zero. Status equals enable AND expiry condition. Writes set bits 0 and 1 only; bit 2 ignores writes.
- R5: The interrupt output is a registered level equal to enable AND NOT mask AND expiry condition of the previous cycle. Clearing the mask while expired raises it one cycle later with no new edge of the condition.
- R6: A write to select 2 loads the deadline with the count seen in the write cycle plus the sign-extended low 32 bits of the write word. The upper write bits are ignored.
- R7: Select 2 reads the low 32 bits of (deadline minus count), sign-extended to 64 bits. After expiry this value is negative and falls by one per clock.
- R8: With enable clear, status reads 0 and the interrupt stays low, even if the condition holds.
- R9: In reset the control bits are zero, the deadline is zero and the interrupt is low.
- R10: Writing enable with mask set drops the interrupt on the following cycle while status keeps reading 1.
- R11: With a future deadline, the interrupt stays low while count <= deadline. It first reads high on the clock when the count equals deadline + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 2 | View select: 0 count, 1 deadline, 2 relative, 3 control |
| bus_wdata | input | 64 | Write word |
| bus_rdata | output | 64 | Read word for the selected view, combinational |
| timer_irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every bus input is stable across each rising edge and holds a defined value once reset has been released. They also assume that a relative write refers to the count present in the same cycle as the strobe. The bench meets these assumptions by changing inputs only just after falling edges. It gives the strobe one cycle per write and leaves the select steady while sampling reads. It keeps deadlines far enough ahead of the count that the no-early-interrupt window is fully observed.

// File: rtl/cmpt_pkg.sv
`timescale 1ns/1ps
package cmpt_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_REL   = 2'd2,
    SEL_CTRL  = 2'd3
  } cmpt_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_MASK_BIT = 1;
  localparam int CTL_STAT_BIT = 2;
  localparam int CTL_USED_W   = 3;
endpackage

// File: rtl/cmpt_rst_sync.sv
`timescale 1ns/1ps
module cmpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/cmpt_counter.sv
`timescale 1ns/1ps
module cmpt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = count + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= count_d;
  end
endmodule

// File: rtl/cmpt_regs.sv
`timescale 1ns/1ps
module cmpt_regs
  import cmpt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_q,
  output logic             en_q,
  output logic             mask_q
);
  localparam int EXT_W = CNT_W - REL_W;

  cmpt_sel_e        sel_e;
  logic [CNT_W-1:0] rel_ext;
  logic [CNT_W-1:0] cmp_d;
  logic             cmp_ld;
  logic             ctl_ld;
  logic             en_d;
  logic             mask_d;

  always_comb begin
    sel_e   = cmpt_sel_e'(sel);
    rel_ext = {{EXT_W{wdata[REL_W-1]}}, wdata[REL_W-1:0]};
    cmp_ld  = wr_en && (sel_e == SEL_CMP || sel_e == SEL_REL);
    ctl_ld  = wr_en && (sel_e == SEL_CTRL);
    if (sel_e == SEL_REL) cmp_d = count + rel_ext;
    else                  cmp_d = wdata;
    en_d    = wdata[CTL_EN_BIT];
    mask_d  = wdata[CTL_MASK_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_ld) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else if (ctl_ld) begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/cmpt_fire.sv
`timescale 1ns/1ps
module cmpt_fire #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp,
  input  logic             en,
  input  logic             mask,
  output logic             status,
  output logic             irq
);
  logic cond;
  logic irq_d;

  always_comb begin
    cond   = (count >= cmp);
    status = en & cond;
    irq_d  = status & ~mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/cmpt_channel.sv
`timescale 1ns/1ps
module cmpt_channel
  import cmpt_pkg::*;
#(
  parameter int CNT_W     = 64,
  parameter int REL_W     = 32,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             timer_irq
);
  localparam int EXT_W = CNT_W - REL_W;
  localparam int PAD_W = CNT_W - CTL_USED_W;

  logic             rst_n_sync;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cmp_q;
  logic             en_q;
  logic             mask_q;
  logic             status;
  logic [CNT_W-1:0] rel_diff;
  logic [CNT_W-1:0] rel_view;
  logic [CNT_W-1:0] ctl_view;

  cmpt_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  cmpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .tick_en (1'b1),
    .count   (count_q)
  );

  cmpt_regs #(.CNT_W(CNT_W), .REL_W(REL_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_en  (bus_wr),
    .sel    (bus_addr),
    .wdata  (bus_wdata),
    .count  (count_q),
    .cmp_q  (cmp_q),
    .en_q   (en_q),
    .mask_q (mask_q)
  );

  cmpt_fire #(.CNT_W(CNT_W)) u_fire (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .count  (count_q),
    .cmp    (cmp_q),
    .en     (en_q),
    .mask   (mask_q),
    .status (status),
    .irq    (timer_irq)
  );

  always_comb begin
    rel_diff = cmp_q - count_q;
    rel_view = {{EXT_W{rel_diff[REL_W-1]}}, rel_diff[REL_W-1:0]};
    ctl_view = {{PAD_W{1'b0}}, status, mask_q, en_q};
    case (cmpt_sel_e'(bus_addr))
      SEL_COUNT: bus_rdata = count_q;
      SEL_CMP:   bus_rdata = cmp_q;
      SEL_REL:   bus_rdata = rel_view;
      default:   bus_rdata = ctl_view;
    endcase
  end
endmodule

// File: rtl/cmpt_channel_chk.sv
`timescale 1ns/1ps
module cmpt_channel_chk #(
  parameter int CNT_W = 64,
  parameter int REL_W = 32
) (
  input logic             clk,
  input logic             rst_n_sync,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] bus_rdata,
  input logic             timer_irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp,
  input logic             en,
  input logic             mask
);
  logic [CNT_W-1:0] w_ext;
  assign w_ext = {{(CNT_W-REL_W){bus_wdata[REL_W-1]}}, bus_wdata[REL_W-1:0]};

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $past(rst_n_sync) |-> count == $past(count) + 64'd1);

  assert_ctl_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_addr == 2'd3) |-> bus_rdata[CNT_W-1:3] == '0);

  assert_rel_load_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_wr && bus_addr == 2'd2) |=> cmp == $past(count) + $past(w_ext));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !en |=> !timer_irq);

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (en && mask) |=> !timer_irq);

  assert_no_early_R11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    timer_irq |-> $past(count >= cmp));
endmodule

bind cmpt_channel cmpt_channel_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
  .clk        (clk),
  .rst_n_sync (rst_n_sync),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .timer_irq  (timer_irq),
  .count      (count_q),
  .cmp        (cmp_q),
  .en         (en_q),
  .mask       (mask_q)
);

// File: tb/cmpt_channel_test.sv
`timescale 1ns/1ps
module cmpt_channel_test;
  localparam logic [1:0] A_CNT = 2'd0, A_CMP = 2'd1, A_REL = 2'd2, A_CTL = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        timer_irq;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  cmpt_channel uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  int          hi;
  logic [63:0] m_cnt, m_cmp;
  logic        m_en, m_mask, m_irq;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hi = 0; m_cnt = 0; m_cmp = 0; m_en = 0; m_mask = 0; m_irq = 0;
    end else if (hi < 2) begin
      hi++;
    end else begin
      logic        nirq;
      logic [63:0] ncmp;
      nirq = m_en && !m_mask && (m_cnt >= m_cmp);
      ncmp = m_cmp;
      if (bus_wr) begin
        if (bus_addr == A_CMP) ncmp = bus_wdata;
        if (bus_addr == A_REL) ncmp = m_cnt + sx(bus_wdata[31:0]);
        if (bus_addr == A_CTL) begin m_en = bus_wdata[0]; m_mask = bus_wdata[1]; end
      end
      m_cmp = ncmp;
      m_irq = nirq;
      m_cnt = m_cnt + 1;
    end
  end

  // Per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && hi >= 2) begin
      logic [63:0] e;
      logic [63:0] d;
      d = m_cmp - m_cnt;
      case (bus_addr)
        A_CNT:   begin e = m_cnt; chk("R1 model count", bus_rdata, e); end
        A_CMP:   begin e = m_cmp; chk("R2 model deadline", bus_rdata, e); end
        A_REL:   begin e = sx(d[31:0]); chk("R7 model relative", bus_rdata, e); end
        default: begin
          e = {61'd0, m_en && (m_cnt >= m_cmp), m_mask, m_en};
          chk("R4 model control", bus_rdata, e);
        end
      endcase
      chk("R5 model irq", {63'd0, timer_irq}, {63'd0, m_irq});
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    #1;
  endtask

  initial begin
    logic [63:0] v, c1, c2, a, b, dl;
    logic        seen, early;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = A_CTL; bus_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset control", bus_rdata, 64'd0);
    chk("R9 reset irq", {63'd0, timer_irq}, 64'd0);
    bus_addr = A_CMP; #1;
    chk("R9 reset deadline", bus_rdata, 64'd0);
    @(negedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk); #1;

    // R1: counting and ignored writes
    rd(A_CNT, c1);
    repeat (9) @(negedge clk);
    rd(A_CNT, c2);
    chk("R1 ten ticks", c2, c1 + 64'd10);
    wr(A_CNT, 64'd0);
    rd(A_CNT, v);
    chk("R1 write ignored", v, c2 + 64'd3);

    // R2: deadline read-back
    wr(A_CMP, 64'hF123_4567_89AB_CDEF);
    rd(A_CMP, v);
    chk("R2 deadline readback", v, 64'hF123_4567_89AB_CDEF);

    // R4: status bit ignores writes, upper bits zero
    wr(A_CTL, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_CTL, v);
    chk("R4 control bits", v, 64'd3);
    chk("R4 masked no irq", {63'd0, timer_irq}, 64'd0);
    wr(A_CTL, 64'd0);

    // R8 / R3: past deadline while disabled
    wr(A_CMP, 64'd0);
    rd(A_CTL, v);
    chk("R8 status low when disabled", v, 64'd0);
    chk("R8 irq low when disabled", {63'd0, timer_irq}, 64'd0);

    // R3 / R5: enable with expired deadline
    wr(A_CTL, 64'd1);
    chk("R5 one cycle latency", {63'd0, timer_irq}, 64'd0);
    rd(A_CTL, v);
    chk("R3 status immediate", v, 64'd5);
    chk("R5 irq level", {63'd0, timer_irq}, 64'd1);

    // R10: handler masks
    wr(A_CTL, 64'd3);
    chk("R10 irq before mask takes effect", {63'd0, timer_irq}, 64'd1);
    rd(A_CTL, v);
    chk("R10 status stays", v, 64'd7);
    chk("R10 irq dropped", {63'd0, timer_irq}, 64'd0);

    // R5: unmask raises level without new edge
    wr(A_CTL, 64'd1);
    rd(A_CTL, v);
    chk("R5 unmask raises irq", {63'd0, timer_irq}, 64'd1);

    // R7: negative and decreasing after expiry
    rd(A_REL, a);
    rd(A_REL, b);
    chk("R7 negative", {63'd0, a[63]}, 64'd1);
    chk("R7 decreasing", b, a - 64'd1);

    // R6: relative load, negative with junk upper bits
    wr(A_CTL, 64'd0);
    rd(A_CNT, c1);
    bus_wr = 1'b1; bus_addr = A_REL; bus_wdata = 64'hABCD_0123_FFFF_FFF0;
    @(negedge clk); #1; bus_wr = 1'b0;
    rd(A_CMP, v);
    chk("R6 negative relative", v, c1 - 64'd16);

    // R6 / R7: positive relative
    rd(A_CNT, c1);
    bus_wr = 1'b1; bus_addr = A_REL; bus_wdata = 64'd100;
    @(negedge clk); #1; bus_wr = 1'b0;
    rd(A_REL, v);
    chk("R7 positive remaining", v, 64'd98);

    // R11: no early fire, exact rise
    rd(A_CNT, c1);
    bus_wr = 1'b1; bus_addr = A_REL; bus_wdata = 64'd20;
    @(negedge clk); #1; bus_wr = 1'b0;
    dl = c1 + 64'd20;
    wr(A_CTL, 64'd1);
    bus_addr = A_CNT;
    seen = 1'b0; early = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (timer_irq && !seen) begin
        seen = 1'b1;
        chk("R11 first rise count", bus_rdata, dl + 64'd1);
      end
      if (timer_irq && bus_rdata <= dl) early = 1'b1;
    end
    chk("R11 no early irq", {63'd0, early}, 64'd0);
    chk("R11 irq seen", {63'd0, seen}, 64'd1);
    #1;
    wr(A_CTL, 64'd0);
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule